// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block sits between a configuration access requester and an outbound packet stream. It takes one configuration read or write at a time. A request names a target bus, a device/function pair, a byte address, an access size of 1, 2 or 4 bytes, and write data. The block turns each request into a three-dword header plus one data dword. It sends them as 64-bit beats, each beat tagged with start and end markers, on a valid/ready stream.

The block keeps its own copy of the root bus number and uses it in three ways. It decides between a type 0 and a type 1 request. It forms the requester ID. It filters the request: a request to the root port's first base address register, or to a device slot that cannot exist, is turned away. A refused request gets a one-cycle error code and puts nothing on the stream.

When a write to the primary bus number register of the root bus has been sent, the block waits for the completion verdict. If that verdict is good, the root bus number takes the low byte of the written data.

Top module: `cfg_req_builder`

## Requirements
- R1: After reset, `outValid` and `errValid` are low, `reqReady` is high, and the root bus number equals `ROOT_BUS_INIT`.
- R2: The format/type byte is 0x04 for a read and 0x44 for a write when the target bus equals the root bus number. It is 0x05 for a read and 0x45 for a write otherwise.
- R3: Header dword 0 has the format/type byte in bits 31:24 and the value 1 in bits 23:0.
- R4: Header dword 1 is built as follows. Bits 31:24 hold the root bus number and bits 23:16 hold `RP_DEVFN`. Bits 15:8 hold the tag, which is 0x1D for reads and 0x10 for writes. Bits 3:0 hold the byte enables, and bits 7:4 are zero.
- R5: Header dword 2 holds the target bus in bits 31:24 and the device/function in bits 23:16. Bits 15:0 hold the byte address with its two low bits cleared.
- R6: `reqSize` 0 selects a byte access: the byte enables are 1<<(addr&3) and the data is wdata[7:0] shifted left by 8*(addr&3). `reqSize` 1 selects a halfword access: the byte enables are 3<<(addr&3) and the data is wdata[15:0] shifted the same way. `reqSize` 2 or 3 selects a dword access: the byte enables are 0xF and the data is unshifted.
- R7: The first beat carries dword 0 in bits 31:0 and dword 1 in bits 63:32, with `outSop` high and `outEop` low. It appears in the cycle after the request is accepted.
- R8: A write whose address has bits 2:0 equal to zero uses three beats. The second beat is {32'h0, dword 2} with both markers low. The third is {32'h0, data} with `outEop` high.
- R9: A read, or a write that is not quadword aligned, uses two beats. The second beat is {data, dword 2} with `outEop` high, and the data is zero for a read.
- R10: While `outValid` is high and `outReady` is low, the beat and its markers hold unchanged.
- R11: After a write to the root bus at dword offset 0x18 is sent, `reqReady` stays low until `cplValid`. The root bus number takes the low byte of the shifted write data only if `cplOk` is high with `cplValid`. Writes to other offsets or buses do not wait.
- R12: A request with target bus equal to the root bus, device/function 0 and byte address 0x10 is refused. `errValid` goes high for one cycle with `errCode` 1, and no beat is sent.
- R13: A request whose device number (devfn bits 7:3) is nonzero is refused when the target bus is the root bus or the root bus plus one. It gets `errCode` 2 for one cycle and no beats. The same device number on any other bus is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBus | input | 8 | Target bus number |
| reqDevFn | input | 8 | Target device (7:3) and function (2:0) |
| reqAddr | input | ADDR_W | Register byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 dword |
| reqWdata | input | 32 | Write value, right-aligned |
| errValid | output | 1 | One-cycle refusal pulse |
| errCode | output | 2 | 1 hidden register, 2 device absent |
| outValid | output | 1 | Beat present |
| outReady | input | 1 | Downstream takes the beat |
| outData | output | 64 | Beat payload |
| outSop | output | 1 | First beat of a packet |
| outEop | output | 1 | Last beat of a packet |
| cplValid | input | 1 | Completion verdict for a pending bus number write |
| cplOk | input | 1 | Completion succeeded |

## Verification
The bench checks five behaviours where a wrong design fails in a visible way.

- Quadword alignment decides the beat count. A design that tests only bit 2, or that treats reads as aligned, sends the wrong number of beats or sets end-of-packet on the wrong beat.
- Byte and halfword writes carry garbage in the upper write bits. A design that shifts before masking leaks those bits into the payload or into the byte enables.
- The root bus number is updated through a failed completion and then a good one. A design that updates too early or ignores the verdict picks the wrong type byte and requester ID on the next request. It also filters the wrong bus pair.
- The refusals are checked for their codes. The hidden register must win over the absent-device check, and a refused request must emit no beat.
- Back-pressure in the middle of a packet must leave the beat unchanged.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_MID, ST_TAIL, ST_WAIT} state_e;

  typedef struct packed {
    logic       load;
    logic [1:0] beatSel;
    logic       rootUpd;
  } ctrlStrobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_BADREG = 2'd1;
  localparam logic [1:0] ERR_ABSENT = 2'd2;

  localparam logic [1:0] SEL_HDR  = 2'd0;
  localparam logic [1:0] SEL_MID  = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;

  localparam logic [7:0] FMT_RD0 = 8'h04;
  localparam logic [7:0] FMT_WR0 = 8'h44;
  localparam logic [7:0] FMT_RD1 = 8'h05;
  localparam logic [7:0] FMT_WR1 = 8'h45;
  localparam logic [7:0] TAG_RD  = 8'h1D;
  localparam logic [7:0] TAG_WR  = 8'h10;

  localparam logic [15:0] BAR0_OFF     = 16'h0010;
  localparam logic [15:0] PRIM_BUS_OFF = 16'h0018;
endpackage

// File: rtl/cfgb_dpath.sv
module cfgb_dpath
  import cfgb_pkg::*;
#(
  parameter int         ADDR_W        = 12,
  parameter logic [7:0] ROOT_BUS_INIT = 8'h00,
  parameter logic [7:0] RP_DEVFN      = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [7:0]        reqBus,
  input  logic [7:0]        reqDevFn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              refuseBad,
  output logic              refuseAbsent,
  output logic              alignedWr,
  output logic              primWr,
  output logic [63:0]       outData
);
  localparam int OFF_W = 16;

  logic [7:0]       rootBus;
  logic [31:0]      hdr0, hdr1, hdr2, payload;
  logic [7:0]       newBusQ;
  logic             isRoot, isBelow;
  logic [1:0]       lane;
  logic [OFF_W-1:0] offFull, offWord;
  logic [3:0]       byteEn;
  logic [31:0]      shData;
  logic [7:0]       typeByte;

  always_comb begin
    isRoot  = (reqBus == rootBus);
    isBelow = (reqBus == rootBus + 8'd1);
    lane    = reqAddr[1:0];
    offFull = OFF_W'(reqAddr);
    offWord = offFull & 16'hFFFC;
    case (reqSize)
      SZ_BYTE: begin
        byteEn = 4'b0001 << lane;
        shData = {24'h0, reqWdata[7:0]} << {lane, 3'b000};
      end
      SZ_HALF: begin
        byteEn = 4'b0011 << lane;
        shData = {16'h0, reqWdata[15:0]} << {lane, 3'b000};
      end
      default: begin
        byteEn = 4'hF;
        shData = reqWdata;
      end
    endcase
    if (reqWrite) typeByte = isRoot ? FMT_WR0 : FMT_WR1;
    else          typeByte = isRoot ? FMT_RD0 : FMT_RD1;
    refuseBad    = isRoot && (reqDevFn == 8'h00) && (offFull == BAR0_OFF);
    refuseAbsent = !refuseBad && (isRoot || isBelow) && (reqDevFn[7:3] != 5'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootBus   <= ROOT_BUS_INIT;
      hdr0      <= '0;
      hdr1      <= '0;
      hdr2      <= '0;
      payload   <= '0;
      newBusQ   <= '0;
      alignedWr <= 1'b0;
      primWr    <= 1'b0;
    end else begin
      if (strobe.load) begin
        hdr0      <= {typeByte, 24'h000001};
        hdr1      <= {rootBus, RP_DEVFN, (reqWrite ? TAG_WR : TAG_RD), 4'h0, byteEn};
        hdr2      <= {reqBus, reqDevFn, offWord};
        payload   <= reqWrite ? shData : 32'h0;
        newBusQ   <= shData[7:0];
        alignedWr <= reqWrite && (reqAddr[2:0] == 3'b000);
        primWr    <= reqWrite && isRoot && (offWord == PRIM_BUS_OFF);
      end
      if (strobe.rootUpd) rootBus <= newBusQ;
    end
  end

  always_comb begin
    case (strobe.beatSel)
      SEL_HDR: outData = {hdr1, hdr0};
      SEL_MID: outData = {(alignedWr ? 32'h0 : payload), hdr2};
      default: outData = {32'h0, payload};
    endcase
  end

  // R11
  root_bus_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rootBus != $past(rootBus)) |-> $past(strobe.rootUpd));

  // R6
  byte_en_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqSize == SZ_BYTE) |=> ($countones(hdr1[3:0]) == 1));
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        refuseBad,
  input  logic        refuseAbsent,
  input  logic        alignedWr,
  input  logic        primWr,
  input  logic        outReady,
  input  logic        cplValid,
  input  logic        cplOk,
  output logic        outValid,
  output logic        outSop,
  output logic        outEop,
  output logic        errValid,
  output logic [1:0]  errCode,
  output ctrlStrobe_t strobe
);
  state_e state, stateNxt;
  logic   accept, refused;

  always_comb begin
    reqReady = (state == ST_IDLE);
    accept   = reqValid && reqReady;
    refused  = refuseBad || refuseAbsent;
    outValid = (state == ST_HDR) || (state == ST_MID) || (state == ST_TAIL);
    outSop   = (state == ST_HDR);
    outEop   = ((state == ST_MID) && !alignedWr) || (state == ST_TAIL);

    strobe.load    = accept && !refused;
    strobe.rootUpd = (state == ST_WAIT) && cplValid && cplOk;
    case (state)
      ST_MID:  strobe.beatSel = SEL_MID;
      ST_TAIL: strobe.beatSel = SEL_TAIL;
      default: strobe.beatSel = SEL_HDR;
    endcase

    stateNxt = state;
    case (state)
      ST_IDLE: if (accept && !refused) stateNxt = ST_HDR;
      ST_HDR:  if (outReady) stateNxt = ST_MID;
      ST_MID:  if (outReady) stateNxt = alignedWr ? ST_TAIL : (primWr ? ST_WAIT : ST_IDLE);
      ST_TAIL: if (outReady) stateNxt = primWr ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (cplValid) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errValid <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      state    <= stateNxt;
      errValid <= accept && refused;
      errCode  <= !(accept && refused) ? ERR_NONE : (refuseBad ? ERR_BADREG : ERR_ABSENT);
    end
  end

  // R12
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> !outValid);

  // R7
  sop_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !refuseBad && !refuseAbsent) |=> (outValid && outSop));

  // R8
  eop_ends_packet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outEop) |=> !outValid);

  // R10
  stall_hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSop) && $stable(outEop)));
endmodule

// File: rtl/cfg_req_builder.sv
module cfg_req_builder
  import cfgb_pkg::*;
#(
  parameter int         ADDR_W        = 12,
  parameter logic [7:0] ROOT_BUS_INIT = 8'h00,
  parameter logic [7:0] RP_DEVFN      = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [7:0]        reqBus,
  input  logic [7:0]        reqDevFn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              errValid,
  output logic [1:0]        errCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [63:0]       outData,
  output logic              outSop,
  output logic              outEop,
  input  logic              cplValid,
  input  logic              cplOk
);
  ctrlStrobe_t strobe;
  logic refuseBad, refuseAbsent, alignedWr, primWr;

  cfgb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .refuseBad(refuseBad), .refuseAbsent(refuseAbsent),
    .alignedWr(alignedWr), .primWr(primWr), .outReady(outReady),
    .cplValid(cplValid), .cplOk(cplOk), .outValid(outValid),
    .outSop(outSop), .outEop(outEop), .errValid(errValid),
    .errCode(errCode), .strobe(strobe)
  );

  cfgb_dpath #(
    .ADDR_W(ADDR_W), .ROOT_BUS_INIT(ROOT_BUS_INIT), .RP_DEVFN(RP_DEVFN)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .refuseBad(refuseBad),
    .refuseAbsent(refuseAbsent), .alignedWr(alignedWr), .primWr(primWr),
    .outData(outData)
  );

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: tb/cfg_req_builder_tb.sv
module cfg_req_builder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [7:0]  reqDevFn = '0;
  logic [11:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        errValid;
  logic [1:0]  errCode;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outData;
  logic        outSop, outEop;
  logic        cplValid = 1'b0;
  logic        cplOk = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] benchRoot = 8'h00;

  always #10 clk = ~clk;

  cfg_req_builder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBus(reqBus), .reqDevFn(reqDevFn),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .errValid(errValid), .errCode(errCode), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outSop(outSop),
    .outEop(outEop), .cplValid(cplValid), .cplOk(cplOk)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] data;
    logic [1:0]  beats;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 8'h00, 12'h004, 2'd2, 32'h0,        4'hF, 32'h0,        2'd2},
    '{1'b0, 8'h03, 8'h08, 12'h102, 2'd1, 32'h0,        4'hC, 32'h0,        2'd2},
    '{1'b0, 8'h01, 8'h02, 12'h007, 2'd0, 32'h0,        4'h8, 32'h0,        2'd2},
    '{1'b1, 8'h00, 8'h00, 12'h020, 2'd2, 32'hCAFEF00D, 4'hF, 32'hCAFEF00D, 2'd3},
    '{1'b1, 8'h02, 8'h11, 12'h00D, 2'd0, 32'hFFFF77A5, 4'h2, 32'h0000A500, 2'd2},
    '{1'b1, 8'h00, 8'h01, 12'h00E, 2'd1, 32'hAAAA1234, 4'hC, 32'h12340000, 2'd2},
    '{1'b1, 8'h05, 8'h20, 12'h008, 2'd1, 32'h5555BEEF, 4'h3, 32'h0000BEEF, 2'd3},
    '{1'b1, 8'h00, 8'h00, 12'h040, 2'd0, 32'hFFFFFF5A, 4'h1, 32'h0000005A, 2'd3},
    '{1'b1, 8'h02, 8'h00, 12'h018, 2'd2, 32'h00000011, 4'hF, 32'h00000011, 2'd3}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expBeat(input logic wr, input logic [7:0] bus,
      input logic [7:0] devfn, input logic [11:0] addr, input logic [3:0] be,
      input logic [31:0] data, input logic [1:0] beats, input int idx);
    logic [7:0]  fmt;
    logic [31:0] d0, d1, d2;
    fmt = (bus == benchRoot) ? (wr ? 8'h44 : 8'h04) : (wr ? 8'h45 : 8'h05);
    d0 = {fmt, 24'h000001};
    d1 = {benchRoot, 8'h00, (wr ? 8'h10 : 8'h1D), 4'h0, be};
    d2 = {bus, devfn, 4'h0, addr[11:2], 2'b00};
    if (idx == 0) return {d1, d0};
    if (beats == 2'd3) return (idx == 1) ? {32'h0, d2} : {32'h0, data};
    return {(wr ? data : 32'h0), d2};
  endfunction

  task automatic runReq(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
      input logic [11:0] addr, input logic [1:0] size, input logic [31:0] wdata,
      input logic [3:0] be, input logic [31:0] data, input logic [1:0] beats,
      input int stallBeat, input string tag);
    logic [63:0] e;
    @(negedge clk);
    check(reqReady == 1'b1, {tag, " R11 ready before request"}, 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqWrite = wr; reqBus = bus; reqDevFn = devfn;
    reqAddr = addr; reqSize = size; reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    for (int b = 0; b < int'(beats); b++) begin
      e = expBeat(wr, bus, devfn, addr, be, data, beats, b);
      // R2 R3 R4 R5 R6 R7 R8 R9: beat contents
      check(outValid && outData == e, {tag, " R2-data beat"}, outData, e);
      check(outSop == (b == 0), {tag, " R7 sop"}, 64'(outSop), 64'(b == 0));
      check(outEop == (b == int'(beats) - 1), {tag, " R8 R9 eop"}, 64'(outEop),
            64'(b == int'(beats) - 1));
      if (b == stallBeat) begin
        outReady = 1'b0;
        @(negedge clk);
        // R10
        check(outValid && outData == e, {tag, " R10 stalled beat"}, outData, e);
        outReady = 1'b1;
      end
      @(negedge clk);
    end
    check(outValid == 1'b0, {tag, " R8 R9 packet ended"}, 64'(outValid), 64'd0);
  endtask

  task automatic runRefused(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
      input logic [11:0] addr, input logic [1:0] code, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBus = bus; reqDevFn = devfn;
    reqAddr = addr; reqSize = 2'd2; reqWdata = 32'h0;
    @(negedge clk);
    reqValid = 1'b0;
    check(errValid && errCode == code, {tag, " error code"}, 64'(errCode), 64'(code));
    check(!outValid, {tag, " no beat"}, 64'(outValid), 64'd0);
    @(negedge clk);
    check(!errValid && !outValid, {tag, " pulse ends"}, 64'({errValid, outValid}), 64'd0);
  endtask

  task automatic sendCpl(input logic ok);
    // R11: waiting for the completion
    check(reqReady == 1'b0, "R11 ready low while waiting", 64'(reqReady), 64'd0);
    cplValid = 1'b1; cplOk = ok;
    @(negedge clk);
    cplValid = 1'b0; cplOk = 1'b0;
    check(reqReady == 1'b1, "R11 ready after completion", 64'(reqReady), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!outValid && !errValid && reqReady, "R1 reset outputs",
          64'({outValid, errValid, reqReady}), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !errValid && reqReady, "R1 after reset",
          64'({outValid, errValid, reqReady}), 64'd1);

    for (int i = 0; i < NVEC; i++)
      runReq(VECS[i].wr, VECS[i].bus, VECS[i].devfn, VECS[i].addr, VECS[i].size,
             VECS[i].wdata, VECS[i].be, VECS[i].data, VECS[i].beats,
             (i % 2 == 1) ? 1 : -1, $sformatf("vec%0d", i));

    // R12 hidden register, and it wins over the device check
    runRefused(1'b0, 8'h00, 8'h00, 12'h010, 2'd1, "R12 read bar");
    runRefused(1'b1, 8'h00, 8'h00, 12'h010, 2'd1, "R12 write bar");
    // R13 absent devices on root and root+1
    runRefused(1'b0, 8'h00, 8'h08, 12'h010, 2'd2, "R13 root dev1");
    runRefused(1'b0, 8'h01, 8'hF8, 12'h000, 2'd2, "R13 below dev31");

    // R11 failed completion leaves root bus alone
    runReq(1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h00000507, 4'hF, 32'h00000507, 2'd3, 0, "R11 prim wr a");
    sendCpl(1'b0);
    runReq(1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 4'hF, 32'h0, 2'd2, -1, "R11 root kept");

    // R11 good completion moves root bus to 0x07
    runReq(1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h00000507, 4'hF, 32'h00000507, 2'd3, -1, "R11 prim wr b");
    sendCpl(1'b1);
    benchRoot = 8'h07;
    runReq(1'b0, 8'h07, 8'h00, 12'h000, 2'd2, 32'h0, 4'hF, 32'h0, 2'd2, -1, "R11 R2 new root type0");
    runReq(1'b0, 8'h00, 8'h08, 12'h004, 2'd2, 32'h0, 4'hF, 32'h0, 2'd2, -1, "R13 old root dev1 allowed");
    runReq(1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 4'hF, 32'h0, 2'd2, -1, "R12 bar off root allowed");
    runRefused(1'b0, 8'h08, 8'h08, 12'h000, 2'd2, "R13 new below dev1");
    runRefused(1'b0, 8'h07, 8'h00, 12'h010, 2'd1, "R12 new root bar");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule